// File: doc/BRIEF.md
# Two-level carry-lookahead adder

This block is a purely combinational 16-bit binary adder. It takes two unsigned operands and a carry-in, and it returns a 16-bit sum and a carry-out. No carry ever passes from bit to bit in a chain.

The operands are split into four 4-bit groups. Each bit forms a generate term (AND of the operand bits) and a propagate term (XOR of the operand bits). Each group computes its internal carries from flattened two-level equations, and it reports a group generate and a group propagate. A second lookahead unit of the same 4-wide form takes those group signals and the carry-in. It produces the carry into each group and the overall carry-out.

The block is meant to be placed inside a datapath where a registered stage sits on either side. Every lookahead unit stays four inputs wide. A wider adder is built by adding another level of hierarchy, not by widening the equations.

Top module: `cla_adder16`

## Requirements
- R1: `sum` equals the low 16 bits of `opnd_a + opnd_b + cin`, taken as unsigned numbers.
- R2: `cout` equals bit 16 of the 17-bit unsigned total `opnd_a + opnd_b + cin`.
- R3: When every bit propagates (`opnd_a ^ opnd_b` is all ones), `cout` equals `cin`. The sum is 0x0000 when `cin` is 1 and 0xFFFF when `cin` is 0.
- R4: When every bit generates (both operands are 0xFFFF), `cout` is 1 and `sum` is 0xFFFE with `cin` added into bit 0.
- R5: The carry into group k+1 (bits 4k+4 and up) equals the group-k generate OR (the group-k propagate AND the carry into group k). The carry out of group 3 is `cout`, and the carry into group 0 is `cin`.
- R6: For fixed operands, setting `cin` from 0 to 1 raises the 17-bit value {`cout`,`sum`} by exactly one, modulo 2^17.
- R7: With both operands zero, `sum` equals `cin` in bit 0 and zero elsewhere, and `cout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First unsigned operand |
| opnd_b | input | 16 | Second unsigned operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of the total |
| cout | output | 1 | Carry out of bit 15 |

## Verification
The assertions assume that the inputs hold still and are known (no X or Z) for as long as the outputs are compared. That holds because the checks run after the combinational logic has settled. The bench changes the operands only on a rising clock edge and samples the outputs on the following falling edge. Every operand pattern it drives (all-propagate, all-generate, carries crossing group boundaries, zeros and random values) is fully defined, so the reference 17-bit sum and the internal group carries are always known.

// File: rtl/cla_pkg.sv
// Package cla_pkg
// Shared width defaults and the flattened lookahead function.
// Assumes: callers pass vectors no wider than CLA_UNIT_W.
package cla_pkg;
    parameter int unsigned CLA_UNIT_W  = 4;
    parameter int unsigned CLA_NUM_GRP = 4;

    // Flattened carry into position 'upto': OR of each generate j<upto masked
    // by all propagates above it, plus cin masked by every propagate below upto.
    function automatic logic flat_carry(input logic [CLA_UNIT_W-1:0] gen,
                                        input logic [CLA_UNIT_W-1:0] prop,
                                        input logic                  cin,
                                        input int                    upto);
        logic acc;
        logic term;
        acc = 1'b0;
        for (int j = 0; j < upto; j++) begin
            term = gen[j];
            for (int k = j + 1; k < upto; k++) begin
                term = term & prop[k];
            end
            acc = acc | term;
        end
        term = cin;
        for (int k = 0; k < upto; k++) begin
            term = term & prop[k];
        end
        return acc | term;
    endfunction
endpackage

// File: rtl/cla_bit_pg.sv
// Module cla_bit_pg
// Forms the per-bit generate (AND) and propagate (XOR) terms for a slice.
// Assumes: purely combinational, with no state and no reset.
module cla_bit_pg #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] gen,
    output logic [W-1:0] prop
);
    // One generate/propagate pair for each bit position.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign gen[i]  = a[i] & b[i];
        assign prop[i] = a[i] ^ b[i];
    end
endmodule

// File: rtl/cla_lookahead.sv
// Module cla_lookahead
// An N-wide lookahead unit. It gives the carry into each position and the
// block generate/propagate, all from flattened equations with no ripple.
// Assumes: N <= cla_pkg::CLA_UNIT_W, so each term needs at most N+1 inputs.
module cla_lookahead
    import cla_pkg::*;
#(
    parameter int unsigned N = CLA_UNIT_W
) (
    input  logic [N-1:0] gen,
    input  logic [N-1:0] prop,
    input  logic         cin,
    output logic [N-1:0] carry,
    output logic         blk_gen,
    output logic         blk_prop
);
    localparam int unsigned PADW = CLA_UNIT_W;

    logic [PADW-1:0] gen_pad;
    logic [PADW-1:0] prop_pad;

    // Zero-extend the inputs to the width that the package function takes.
    always_comb begin
        gen_pad  = '0;
        prop_pad = '0;
        gen_pad[N-1:0]  = gen;
        prop_pad[N-1:0] = prop;
    end

    // Carry into position i; position 0 receives cin directly.
    for (genvar i = 0; i < N; i++) begin : g_carry
        assign carry[i] = flat_carry(gen_pad, prop_pad, cin, i);
    end

    // Block generate ignores cin; block propagate is the AND of all propagates.
    assign blk_gen  = flat_carry(gen_pad, prop_pad, 1'b0, N);
    assign blk_prop = &prop;
endmodule

// File: rtl/cla_group.sv
// Module cla_group
// One group of the adder: the bit terms, the internal lookahead and the sum bits.
// Assumes: grp_cin comes from the next lookahead level up, never from a neighbour.
module cla_group #(
    parameter int unsigned GW = 4
) (
    input  logic [GW-1:0] a,
    input  logic [GW-1:0] b,
    input  logic          grp_cin,
    output logic [GW-1:0] sum,
    output logic          grp_gen,
    output logic          grp_prop
);
    logic [GW-1:0] gen;
    logic [GW-1:0] prop;
    logic [GW-1:0] carry;

    cla_bit_pg #(.W(GW)) u_pg (
        .a    (a),
        .b    (b),
        .gen  (gen),
        .prop (prop)
    );

    cla_lookahead #(.N(GW)) u_la (
        .gen      (gen),
        .prop     (prop),
        .cin      (grp_cin),
        .carry    (carry),
        .blk_gen  (grp_gen),
        .blk_prop (grp_prop)
    );

    // Each sum bit is its propagate XOR the carry into that bit.
    assign sum = prop ^ carry;
endmodule

// File: rtl/cla_adder16.sv
// Module cla_adder16
// A two-level carry-lookahead adder. The groups report generate/propagate to a
// second lookahead unit, and that unit returns each group's carry-in.
// Assumes: a combinational block, so it has no clock and no reset.
module cla_adder16
    import cla_pkg::*;
#(
    parameter int unsigned GROUP_W    = CLA_UNIT_W,
    parameter int unsigned NUM_GROUPS = CLA_NUM_GRP
) (
    input  logic [GROUP_W*NUM_GROUPS-1:0] opnd_a,
    input  logic [GROUP_W*NUM_GROUPS-1:0] opnd_b,
    input  logic                          cin,
    output logic [GROUP_W*NUM_GROUPS-1:0] sum,
    output logic                          cout
);
    localparam int unsigned WIDTH = GROUP_W * NUM_GROUPS;

    logic [NUM_GROUPS-1:0] grp_gen;
    logic [NUM_GROUPS-1:0] grp_prop;
    logic [NUM_GROUPS-1:0] grp_cin;
    logic                  top_gen;
    logic                  top_prop;

    // One group for each GROUP_W slice of the operands.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        cla_group #(.GW(GROUP_W)) u_grp (
            .a        (opnd_a[g*GROUP_W +: GROUP_W]),
            .b        (opnd_b[g*GROUP_W +: GROUP_W]),
            .grp_cin  (grp_cin[g]),
            .sum      (sum[g*GROUP_W +: GROUP_W]),
            .grp_gen  (grp_gen[g]),
            .grp_prop (grp_prop[g])
        );
    end

    // Second level: the carry into each group from the group terms.
    cla_lookahead #(.N(NUM_GROUPS)) u_top_la (
        .gen      (grp_gen),
        .prop     (grp_prop),
        .cin      (cin),
        .carry    (grp_cin),
        .blk_gen  (top_gen),
        .blk_prop (top_prop)
    );

    // Overall carry-out from the generate/propagate of all WIDTH bits.
    assign cout = top_gen | (top_prop & cin);

    if (WIDTH != 16) begin : g_width_note
        // Other widths are legal; the brief describes the 16-bit default.
    end
endmodule

// File: rtl/cla_adder16_chk.sv
// Module cla_adder16_chk
// A checker bound to cla_adder16. It compares the outputs with a reference
// sum and relates the group carries to the group terms.
// Assumes: the inputs are known and stable while the checks are evaluated.
module cla_adder16_chk #(
    parameter int unsigned GROUP_W    = 4,
    parameter int unsigned NUM_GROUPS = 4
) (
    input logic [GROUP_W*NUM_GROUPS-1:0] opnd_a,
    input logic [GROUP_W*NUM_GROUPS-1:0] opnd_b,
    input logic                          cin,
    input logic [GROUP_W*NUM_GROUPS-1:0] sum,
    input logic                          cout,
    input logic [NUM_GROUPS-1:0]         grp_gen,
    input logic [NUM_GROUPS-1:0]         grp_prop,
    input logic [NUM_GROUPS-1:0]         grp_cin
);
    localparam int unsigned WIDTH = GROUP_W * NUM_GROUPS;

    logic [WIDTH:0] ref_total;

    // Reference total from an ordinary behavioural addition.
    always_comb begin
        ref_total = {1'b0, opnd_a} + {1'b0, opnd_b} + {{WIDTH{1'b0}}, cin};
    end

    // Output and group-carry relations, checked whenever the inputs change.
    always_comb begin
        a_r1_sum_matches: assert (sum == ref_total[WIDTH-1:0])
            else $error("R1 sum mismatch");
        a_r2_cout_matches: assert (cout == ref_total[WIDTH])
            else $error("R2 cout mismatch");
        a_r3_all_prop: assert (!((opnd_a ^ opnd_b) == {WIDTH{1'b1}}) ||
                               (cout == cin && sum == {WIDTH{~cin}}))
            else $error("R3 all-propagate result wrong");
        a_r4_all_gen: assert (!((opnd_a & opnd_b) == {WIDTH{1'b1}}) ||
                              (cout && sum[WIDTH-1:1] == {(WIDTH-1){1'b1}} && sum[0] == cin))
            else $error("R4 all-generate result wrong");
        a_r5_first_cin: assert (grp_cin[0] == cin)
            else $error("R5 group 0 carry-in differs from cin");
        a_r5_last_cout: assert (cout == (grp_gen[NUM_GROUPS-1] |
                                (grp_prop[NUM_GROUPS-1] & grp_cin[NUM_GROUPS-1])))
            else $error("R5 last group carry-out differs from cout");
        a_r7_zero_ops: assert (!(opnd_a == '0 && opnd_b == '0) ||
                               (cout == 1'b0 && sum == {{(WIDTH-1){1'b0}}, cin}))
            else $error("R7 zero operands result wrong");
    end

    // Group k+1 carry-in matches group k's carry-out.
    for (genvar k = 0; k + 1 < NUM_GROUPS; k++) begin : g_link
        always_comb begin
            a_r5_group_link: assert (grp_cin[k+1] == (grp_gen[k] | (grp_prop[k] & grp_cin[k])))
                else $error("R5 group carry link broken");
        end
    end
endmodule

bind cla_adder16 cla_adder16_chk #(
    .GROUP_W    (GROUP_W),
    .NUM_GROUPS (NUM_GROUPS)
) u_chk (
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .cin      (cin),
    .sum      (sum),
    .cout     (cout),
    .grp_gen  (grp_gen),
    .grp_prop (grp_prop),
    .grp_cin  (grp_cin)
);

// File: tb/cla_adder16_tb.sv
// Module cla_adder16_tb
// Directed bench: each task drives one scenario and checks its own results
// against a 17-bit reference computed here.
module cla_adder16_tb;
    logic        clk;
    logic        rst_n;
    logic [15:0] opnd_a;
    logic [15:0] opnd_b;
    logic        cin;
    logic [15:0] sum;
    logic        cout;

    int checks;
    int errors;
    int cycles;
    bit done;

    cla_adder16 u_dut (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .cin    (cin),
        .sum    (sum),
        .cout   (cout)
    );

    // 200 MHz clock.
    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Cycle counter for the watchdog.
    always_ff @(posedge clk) begin
        if (!rst_n) cycles <= 0;
        else        cycles <= cycles + 1;
    end

    // Drive a vector on the rising edge; the result is read on the falling edge.
    task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c);
        @(posedge clk);
        opnd_a = a;
        opnd_b = b;
        cin    = c;
        @(negedge clk);
    endtask

    // Compare both outputs with the reference 17-bit total.
    task automatic check_ref(input string req);
        logic [16:0] exp;
        exp = {1'b0, opnd_a} + {1'b0, opnd_b} + {16'd0, cin};
        checks++;
        if ({cout, sum} != exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h",
                     req, opnd_a, opnd_b, cin, {cout, sum}, exp);
        end
    endtask

    // Compare the outputs with an explicit expected value.
    task automatic check_val(input string req, input logic [16:0] exp);
        checks++;
        if ({cout, sum} != exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h",
                     req, opnd_a, opnd_b, cin, {cout, sum}, exp);
        end
    endtask

    // R7: the state just after reset, with zero operands and both carry-in values.
    task automatic t_zero();
        apply(16'h0000, 16'h0000, 1'b0); check_val("R7", 17'h00000);
        apply(16'h0000, 16'h0000, 1'b1); check_val("R7", 17'h00001);
    endtask

    // R3: every bit propagates.
    task automatic t_all_prop();
        apply(16'hFFFF, 16'h0000, 1'b1); check_val("R3", 17'h10000);
        apply(16'hFFFF, 16'h0000, 1'b0); check_val("R3", 17'h0FFFF);
        apply(16'hA5C3, 16'h5A3C, 1'b1); check_val("R3", 17'h10000);
        apply(16'h0F0F, 16'hF0F0, 1'b0); check_val("R3", 17'h0FFFF);
    endtask

    // R4: every bit generates.
    task automatic t_all_gen();
        apply(16'hFFFF, 16'hFFFF, 1'b0); check_val("R4", 17'h1FFFE);
        apply(16'hFFFF, 16'hFFFF, 1'b1); check_val("R4", 17'h1FFFF);
    endtask

    // R5: carries crossing each group boundary.
    task automatic t_group_cross();
        apply(16'h000F, 16'h0001, 1'b0); check_val("R5", 17'h00010);
        apply(16'h00FF, 16'h0000, 1'b1); check_val("R5", 17'h00100);
        apply(16'h0F00, 16'h0100, 1'b0); check_val("R5", 17'h01000);
        apply(16'hF000, 16'h1000, 1'b0); check_val("R5", 17'h10000);
        apply(16'h0888, 16'h0888, 1'b0); check_val("R5", 17'h01110);
    endtask

    // R6: carry-in raises the total by exactly one.
    task automatic t_cin_step();
        logic [16:0] base;
        apply(16'h1234, 16'h4321, 1'b0);
        base = {cout, sum};
        apply(16'h1234, 16'h4321, 1'b1); check_val("R6", base + 17'd1);
        apply(16'hFFFE, 16'h0001, 1'b0);
        base = {cout, sum};
        apply(16'hFFFE, 16'h0001, 1'b1); check_val("R6", base + 17'd1);
    endtask

    // R1, R2: random operands checked against the behavioural sum.
    task automatic t_random();
        for (int n = 0; n < 300; n++) begin
            apply(16'($urandom), 16'($urandom), 1'($urandom));
            check_ref("R1/R2");
        end
    endtask

    // Watchdog: a hung run is counted as a failure and still prints the summary.
    initial begin
        wait (cycles > 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Main sequence.
    initial begin
        checks = 0;
        errors = 0;
        done   = 1'b0;
        rst_n  = 1'b0;
        opnd_a = '0;
        opnd_b = '0;
        cin    = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_zero();
        t_all_prop();
        t_all_gen();
        t_group_cross();
        t_cin_step();
        t_random();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule